// File: doc/BRIEF.md
# Configuration Data Width Adapter

This block sits between a word-wide write port and the parallel configuration interface of a programmable device. Each 32-bit configuration word arrives through a ready/valid handshake. The block then places the word on a parallel data bus, either as one 32-bit beat or as two 16-bit beats, and produces a configuration clock alongside it. Each beat receives one, two, four or eight clock pulses, so the device can spend extra clocks on each beat when it is decrypting or decompressing the stream internally.

A 4-bit mode select sets both the bus width and the clocks-per-beat figure. The block samples the mode select, the data-enable bit and a byte-count field once, at the moment it accepts a word. When the data-enable bit is clear, or the mode select holds a reserved code, the word is still accepted but it is thrown away and no clocks are produced. The byte-count field handles the tail of a stream: for a final partial word it keeps only the low bytes and forces the remaining bytes to zero.

Top module: `cfgw_adapter`

## Requirements
- R1: Bit 3 of `mode_sel` selects the bus width: 1 gives 32 bits, 0 gives 16 bits. Bits 1:0 set the pulses per beat. With a 16-bit bus, codes 0, 1 and 2 give 1, 2 and 4 pulses. With a 32-bit bus, the same codes give 1, 4 and 8 pulses. Bit 2 has no effect.
- R2: A word accepted while `mode_sel[1:0]` is 3 is discarded and produces no clock pulse.
- R3: A word accepted while `wr_enable` is 0 is discarded, produces no clock pulse, and leaves `wr_ready` high.
- R4: Each clock pulse is high for exactly one cycle and is preceded by at least one low cycle. `cfg_data` does not change in the cycle in which `cfg_clk` is high. A beat with N pulses lasts 2N cycles.
- R5: In 16-bit mode, bits 15:0 of the word are sent as the first beat and bits 31:16 as the second. In both beats, `cfg_data[31:16]` is zero.
- R6: In 32-bit mode, the whole word is sent as a single beat.
- R7: `wr_nbytes` gives the number of valid bytes: 0 means all four, and 1, 2 or 3 keep that many low bytes and zero the rest.
- R8: `wr_ready` goes low in the cycle after a word is accepted for transfer. It stays low until the high cycle of the word's last pulse has ended, and it is high in the next cycle. `cfg_clk` never pulses while `wr_ready` is high.
- R9: `mode_sel`, `wr_enable` and `wr_nbytes` are sampled only when a word is accepted. Changing them while a word is being sent does not alter that word.
- R10: After reset, `cfg_clk` is 0, `wr_ready` is 1 and `cfg_data` is 0. While idle, and across discarded words, `cfg_data` keeps the last beat that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write port: a word is offered |
| wr_ready | output | 1 | Write port: the block can take a word |
| wr_data | input | 32 | Configuration word |
| wr_nbytes | input | 2 | Valid byte count (0 = all four) |
| wr_enable | input | 1 | Data-enable control bit |
| mode_sel | input | 4 | Mode select giving bus width and pulses per beat |
| cfg_data | output | 32 | Parallel configuration data bus |
| cfg_clk | output | 1 | Configuration clock |

## Verification
Two events can land on the same edge: the end of the last pulse of one word, and the acceptance of the next word offered on the write port. The bench holds `wr_valid` high across successive words. While the first word is still being clocked, it also changes the mode, enable and byte-count inputs. It judges the result by capturing every high cycle of `cfg_clk` along with its data value. The captured list must match the two words laid end to end, with each word keeping its own width and ratio, and there must be no merged, lost or doubled pulse at the joint.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  localparam int unsigned WORD_W        = 32;
  localparam int unsigned HALF_W        = 16;
  localparam int unsigned MSEL_W        = 4;
  localparam int unsigned RLOG_MAX      = 3;
  localparam int unsigned RLOG_W        = $clog2(RLOG_MAX + 1);
  localparam int unsigned CNT_W         = RLOG_MAX + 1;
  localparam int unsigned BYTES_PER_W   = WORD_W / 8;
  localparam int unsigned NBYTE_W       = $clog2(BYTES_PER_W);

  typedef struct packed {
    logic              valid;
    logic              wide;
    logic [RLOG_W-1:0] rlog;
  } mode_t;

  // Mode select to width / clocks-per-beat (log2).
  function automatic mode_t decode_mode(input logic [MSEL_W-1:0] msel);
    mode_t m;
    m.valid = 1'b1;
    m.wide  = msel[3];
    unique case (msel[1:0])
      2'd0:    m.rlog = RLOG_W'(0);
      2'd1:    m.rlog = msel[3] ? RLOG_W'(2) : RLOG_W'(1);
      2'd2:    m.rlog = msel[3] ? RLOG_W'(3) : RLOG_W'(2);
      default: begin m.rlog = RLOG_W'(0); m.valid = 1'b0; end
    endcase
    return m;
  endfunction

  // Keep the low n bytes of a word, n == 0 meaning all of them.
  function automatic logic [WORD_W-1:0] keep_low_bytes(
      input logic [WORD_W-1:0] w, input logic [NBYTE_W-1:0] n);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < int'(BYTES_PER_W); i++)
      m[i*8 +: 8] = ((n == '0) || (i < int'(n))) ? 8'hFF : 8'h00;
    return w & m;
  endfunction

  function automatic logic [CNT_W-1:0] pulses_of(input logic [RLOG_W-1:0] rl);
    return CNT_W'(1) << rl;
  endfunction

endpackage

// File: rtl/cfgw_mode_dec.sv
module cfgw_mode_dec
  import cfgw_pkg::*;
(
  input  logic [MSEL_W-1:0] mode_sel,
  output mode_t             mode
);
  always_comb mode = decode_mode(mode_sel);
endmodule

// File: rtl/cfgw_word_buf.sv
module cfgw_word_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wide,
  input  logic [WORD_W-1:0] load_word,
  input  logic              next_beat,
  output logic [WORD_W-1:0] bus
);
  localparam int unsigned HI_W = WORD_W - HALF_W;

  logic [WORD_W-1:0] bus_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      hi_q  <= '0;
    end else if (load) begin
      bus_q <= load_wide ? load_word : WORD_W'(load_word[HALF_W-1:0]);
      hi_q  <= load_word[WORD_W-1:HALF_W];
    end else if (next_beat) begin
      bus_q <= WORD_W'(hi_q);
    end
  end

  assign bus = bus_q;
endmodule

// File: rtl/cfgw_pulse_seq.sv
module cfgw_pulse_seq #(
  parameter int unsigned RLOG_W = 2,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wide,
  input  logic [RLOG_W-1:0] load_rlog,
  output logic              busy,
  output logic              cfg_clk,
  output logic              next_beat,
  output logic              word_done,
  output logic              narrow
);
  logic              busy_q, phase_q, last_q, wide_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RLOG_W-1:0] rlog_q;
  logic              pulse_end;

  function automatic logic [CNT_W-1:0] count_for(input logic [RLOG_W-1:0] rl);
    return CNT_W'(1) << rl;
  endfunction

  assign pulse_end = busy_q && phase_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      last_q  <= 1'b0;
      wide_q  <= 1'b0;
      cnt_q   <= '0;
      rlog_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      last_q  <= load_wide;
      wide_q  <= load_wide;
      rlog_q  <= load_rlog;
      cnt_q   <= count_for(load_rlog);
    end else if (busy_q) begin
      if (pulse_end) begin
        phase_q <= 1'b0;
        if (last_q) begin
          busy_q <= 1'b0;
        end else begin
          last_q <= 1'b1;
          cnt_q  <= count_for(rlog_q);
        end
      end else begin
        phase_q <= ~phase_q;
        if (phase_q) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign cfg_clk   = phase_q;
  assign next_beat = pulse_end && !last_q;
  assign word_done = pulse_end && last_q;
  assign narrow    = busy_q && !wide_q;
endmodule

// File: rtl/cfgw_adapter.sv
module cfgw_adapter
  import cfgw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NBYTE_W-1:0] wr_nbytes,
  input  logic               wr_enable,
  input  logic [MSEL_W-1:0]  mode_sel,
  output logic [WORD_W-1:0]  cfg_data,
  output logic               cfg_clk
);
  mode_t             mode;
  logic              busy;
  logic              accept, start_evt, discard_evt;
  logic              next_beat, word_done, narrow_beat;
  logic [WORD_W-1:0] masked;

  cfgw_mode_dec u_dec (.mode_sel(mode_sel), .mode(mode));

  assign wr_ready    = !busy;
  assign accept      = wr_valid && wr_ready;
  assign start_evt   = accept && wr_enable && mode.valid;
  assign discard_evt = accept && !(wr_enable && mode.valid);
  assign masked      = keep_low_bytes(wr_data, wr_nbytes);

  cfgw_pulse_seq #(.RLOG_W(RLOG_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_wide(mode.wide),
    .load_rlog(mode.rlog), .busy(busy), .cfg_clk(cfg_clk),
    .next_beat(next_beat), .word_done(word_done), .narrow(narrow_beat));

  cfgw_word_buf #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_wide(mode.wide),
    .load_word(masked), .next_beat(next_beat), .bus(cfg_data));
endmodule

// File: rtl/cfgw_adapter_chk.sv
module cfgw_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ready,
  input logic        cfg_clk,
  input logic [31:0] cfg_data,
  input logic        start_evt,
  input logic        discard_evt,
  input logic        word_done,
  input logic        narrow_beat
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |=> !cfg_clk);                                   // R4
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_data));                          // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_beat |-> (cfg_data[31:16] == 16'h0));             // R5
  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !wr_ready);                                // R8
  AST_DONE_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> wr_ready);                                 // R8
  AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !cfg_clk);                                  // R8
  AST_DISCARD_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |=> (wr_ready && !cfg_clk && $stable(cfg_data))); // R3
endmodule

bind cfgw_adapter cfgw_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .cfg_clk(cfg_clk),
  .cfg_data(cfg_data), .start_evt(start_evt), .discard_evt(discard_evt),
  .word_done(word_done), .narrow_beat(narrow_beat));

// File: tb/cfgw_adapter_tb.sv
module cfgw_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_nbytes = '0;
  logic        wr_enable = 1'b0;
  logic [3:0]  mode_sel = '0;
  logic [31:0] cfg_data;
  logic        cfg_clk;

  always #2 clk = ~clk;

  cfgw_adapter u_dut (.*);

  int checks = 0;
  int fails  = 0;
  logic [31:0] cap_d [64];
  int          cap_n = 0;
  logic [31:0] exp_d [64];
  int          exp_n = 0;
  logic [31:0] last_bus = '0;

  typedef struct packed {
    logic [3:0]  msel;
    logic        en;
    logic [1:0]  nb;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{4'd0,  1'b1, 2'd0, 32'hA5A51234},   // R1 R5 16-bit x1
    '{4'd1,  1'b1, 2'd0, 32'h0F0E0D0C},   // R1 16-bit x2
    '{4'd2,  1'b1, 2'd0, 32'hCAFE8001},   // R1 16-bit x4
    '{4'd6,  1'b1, 2'd0, 32'h13579BDF},   // R1 bit2 ignored
    '{4'd8,  1'b1, 2'd0, 32'hDEADBEEF},   // R6 32-bit x1
    '{4'd9,  1'b1, 2'd0, 32'h01234567},   // R1 32-bit x4
    '{4'd10, 1'b1, 2'd0, 32'h89ABCDEF},   // R1 32-bit x8
    '{4'd13, 1'b1, 2'd0, 32'h55AA33CC},   // R1 bit2 ignored, x4
    '{4'd8,  1'b1, 2'd3, 32'hFFEEDDCC},   // R7 three bytes
    '{4'd1,  1'b1, 2'd1, 32'h7766F5E4},   // R7 one byte, 16-bit
    '{4'd8,  1'b0, 2'd0, 32'h11111111},   // R3 disabled
    '{4'd3,  1'b1, 2'd0, 32'h22222222},   // R2 reserved code
    '{4'd4,  1'b1, 2'd2, 32'h9988ABCD}    // R7 two bytes, 16-bit x1
  };

  always @(negedge clk) if (rst_n && cfg_clk) begin
    if (cap_n < 64) cap_d[cap_n] = cfg_data;
    cap_n++;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected pulse list built from the requirements.
  task automatic add_exp(input vec_t v);
    logic [31:0] w;
    int r;
    if (!v.en || v.msel[1:0] == 2'd3) return;
    w = (v.nb == 0) ? v.data : v.data & ((32'h1 << (8 * v.nb)) - 1);
    if (v.msel[3]) r = (v.msel[1:0] == 0) ? 1 : (v.msel[1:0] == 1) ? 4 : 8;
    else           r = (v.msel[1:0] == 0) ? 1 : (v.msel[1:0] == 1) ? 2 : 4;
    if (v.msel[3]) begin
      for (int i = 0; i < r; i++) begin exp_d[exp_n] = w; exp_n++; end
    end else begin
      for (int i = 0; i < r; i++) begin exp_d[exp_n] = {16'h0, w[15:0]}; exp_n++; end
      for (int i = 0; i < r; i++) begin exp_d[exp_n] = {16'h0, w[31:16]}; exp_n++; end
    end
  endtask

  task automatic push(input vec_t v);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = v.data; wr_nbytes = v.nb;
    wr_enable = v.en; mode_sel = v.msel;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_lists();
    @(posedge clk);
    #1 cap_n = 0; exp_n = 0;
  endtask

  task automatic compare(input string req);
    check(cap_n == exp_n, {req, " pulse count"}, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++)
      check(cap_d[i] == exp_d[i], {req, " beat data"}, cap_d[i], exp_d[i]);
    if (exp_n > 0) last_bus = exp_d[exp_n-1];
    check(cfg_data == last_bus, {req, " R10 idle hold"}, cfg_data, last_bus);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=idle");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_clk == 1'b0, "R10 reset clk", 32'(cfg_clk), 0);
    check(wr_ready == 1'b1, "R10 reset ready", 32'(wr_ready), 1);
    check(cfg_data == 32'h0, "R10 reset bus", cfg_data, 0);

    for (int k = 0; k < 13; k++) begin
      clear_lists();
      add_exp(VECS[k]);
      push(VECS[k]);
      @(negedge clk);
      check(wr_ready == (exp_n == 0), "R8 ready after accept (R2 R3 when discarded)",
            32'(wr_ready), 32'(exp_n == 0));
      wait_idle();
      compare("R1 R5 R6 R7 vector");
    end

    // R9 + joint: second word queued with different mode while first runs.
    clear_lists();
    add_exp('{4'd0, 1'b1, 2'd0, 32'h4444BBBB});
    add_exp('{4'd10, 1'b1, 2'd1, 32'h000000F1});
    push('{4'd0, 1'b1, 2'd0, 32'h4444BBBB});
    push('{4'd10, 1'b1, 2'd1, 32'h000000F1});
    wait_idle();
    compare("R9 back-to-back mode change");

    // R9/R3: enable dropped while a long word is being sent.
    clear_lists();
    add_exp('{4'd2, 1'b1, 2'd0, 32'h6E6E1A1A});
    push('{4'd2, 1'b1, 2'd0, 32'h6E6E1A1A});
    push('{4'd9, 1'b0, 2'd0, 32'h77777777});
    wait_idle();
    compare("R9 R3 enable dropped mid-word");

    // R4: a 32-bit x8 beat spans 16 busy cycles.
    clear_lists();
    push('{4'd10, 1'b1, 2'd0, 32'h0BADF00D});
    begin
      int busy_cycles = 0;
      @(negedge clk);
      while (!wr_ready) begin busy_cycles++; @(negedge clk); end
      check(busy_cycles == 16, "R4 beat length", 32'(busy_cycles), 16);
    end
    last_bus = 32'h0BADF00D;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule